// File: doc/BRIEF.md
# USB Device Interrupt Aggregator

This block gathers event flags from a USB device engine into one sticky status word. It masks that word with a per-bit enable word and a global enable, and drives a single interrupt pin. Firmware reads the status word through a small register port. Bus-reset, resume, short-packet end, transfer end and frame-start flags clear when the status word is read. Each endpoint flag clears only when the engine reports a read of that endpoint's own status register, which arrives as a strobe. One bit of the status word is not stored: it shows the live state of the USB bus.

The pin has two configuration bits. One selects active-high or active-low. The other selects level signalling or a pulse of fixed width. In pulse mode a pulse starts when the OR of the enabled pending flags rises from 0 to 1. Reads and writes use separate addresses. The pin output and the read data are both registered.

Top module: `usb_irq_aggregator`

## Requirements
- R1: A one-cycle high on `gen_evt[i]` or `ep_evt[j]` sets a sticky status bit. The status word is read at address 0x10 and laid out as follows: bits 4:0 are `gen_evt` bits 4:0 (bus reset, resume, short-packet end, transfer end, frame start), bit 5 is the bus-status bit, and bit 6+j is endpoint j. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R2: In level mode the pin is active one cycle after some status bit is set whose enable bit is 1 (enable word: write 0x20, read 0x21, same layout as status), provided the global enable is 1. The pin is inactive when no enabled bit is pending.
- R3: While the global enable (bit 0 of the mode word; write 0x30, read 0x31) is 0, the pin holds its inactive level one cycle later, whatever is pending. The status bits are kept.
- R4: After reset the enable, mode and configuration words read 0, so the pin is active-low in level mode and idles at 1. Configuration word (write 0x40, read 0x41): bit 0 = 1 selects active-high, bit 1 = 1 selects pulse mode.
- R5: In pulse mode a 0-to-1 change of the enabled-pending OR produces an active pulse exactly PULSE_W cycles long (8 by default). A new 0-to-1 change during a pulse neither restarts nor lengthens it.
- R6: A status read returns the value held before the read and clears bits 4:0.
- R7: A status read leaves the endpoint bits set. A high on `ep_rd[j]` clears endpoint bit j.
- R8: Bit 5 of a status read equals `bus_status` at the read cycle. It never affects the pin.
- R9: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: A write to the status read address 0x10 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_evt | input | 5 | Bus-level event strobes |
| ep_evt | input | NUM_EP | Endpoint event strobes |
| ep_rd | input | NUM_EP | Endpoint status register read strobes |
| bus_status | input | 1 | Live USB bus state |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The hardest case to reach is a second 0-to-1 change of the pending OR while a pulse is still running. The OR has to drop and rise again inside the pulse window. The bench does this by reading the status word during the pulse, which clears the frame-start flag, and strobing that flag again the next cycle. It then counts the active samples across the whole window. The same-cycle race between an event and its clear is driven directly: a status read or an endpoint read strobe is placed in the same clock as the matching event strobe.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int GEN_N = 5;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_STAT_RD = 8'h10;
  localparam logic [ADDR_W-1:0] A_EN_WR   = 8'h20;
  localparam logic [ADDR_W-1:0] A_EN_RD   = 8'h21;
  localparam logic [ADDR_W-1:0] A_MODE_WR = 8'h30;
  localparam logic [ADDR_W-1:0] A_MODE_RD = 8'h31;
  localparam logic [ADDR_W-1:0] A_CFG_WR  = 8'h40;
  localparam logic [ADDR_W-1:0] A_CFG_RD  = 8'h41;

  typedef struct packed {
    logic pulse_mode;
    logic act_high;
  } pin_cfg_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
#(
  parameter int NUM_EP = 15,
  localparam int EVT_W = GEN_N + NUM_EP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] set_vec,
  input  logic             stat_clr,
  input  logic [NUM_EP-1:0] ep_clr,
  output logic [EVT_W-1:0] flags_q
);
  genvar b;
  generate
    for (b = 0; b < EVT_W; b++) begin : g_bit
      logic clr;
      if (b < GEN_N) begin : g_gen
        assign clr = stat_clr;
      end else begin : g_ep
        assign clr = ep_clr[b-GEN_N];
      end
      always_ff @(posedge clk) begin
        if (rst)             flags_q[b] <= 1'b0;
        else if (set_vec[b]) flags_q[b] <= 1'b1;
        else if (clr)        flags_q[b] <= 1'b0;
      end
    end
  endgenerate

  assert_evt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  assert_gen_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && set_vec[GEN_N-1:0] == '0) |=> (flags_q[GEN_N-1:0] == '0));

  assert_ep_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && ep_clr == '0) |=>
      ((flags_q[EVT_W-1:GEN_N] & $past(flags_q[EVT_W-1:GEN_N])) == $past(flags_q[EVT_W-1:GEN_N])));
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [STAT_W-1:0] stat_word,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [STAT_W-1:0] en_q,
  output logic              glob_en_q,
  output pin_cfg_t          cfg_q,
  output logic              stat_clr
);
  assign stat_clr = reg_rd && (reg_addr == A_STAT_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      glob_en_q <= 1'b0;
      cfg_q     <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_EN_WR:   en_q      <= reg_wdata[STAT_W-1:0];
        A_MODE_WR: glob_en_q <= reg_wdata[0];
        A_CFG_WR:  cfg_q     <= pin_cfg_t'(reg_wdata[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STAT_RD: reg_rdata <= DATA_W'(stat_word);
        A_EN_RD:   reg_rdata <= DATA_W'(en_q);
        A_MODE_RD: reg_rdata <= DATA_W'(glob_en_q);
        A_CFG_RD:  reg_rdata <= DATA_W'(cfg_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assert_stat_wr_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_STAT_RD) |=>
      (en_q == $past(en_q) && glob_en_q == $past(glob_en_q) && cfg_q == $past(cfg_q)));
endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper
  import irq_agg_pkg::*;
#(
  parameter int PULSE_W = 8,
  localparam int CNT_W = $clog2(PULSE_W + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pend_any,
  input  logic     glob_en,
  input  pin_cfg_t cfg,
  output logic     irq_pin
);
  logic             any_g, any_prev_q, rise, start, active_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  assign any_g = pend_any && glob_en;
  assign rise  = any_g && !any_prev_q;
  assign start = cfg.pulse_mode && rise && (cnt_q == '0);

  always_comb begin
    cnt_nx = cnt_q;
    if (start)              cnt_nx = CNT_W'(PULSE_W - 1);
    else if (cnt_q != '0)   cnt_nx = cnt_q - CNT_W'(1);
    if (!cfg.pulse_mode)    cnt_nx = '0;
  end

  always_comb begin
    if (!glob_en)             active_nx = 1'b0;
    else if (cfg.pulse_mode)  active_nx = start || (cnt_q != '0);
    else                      active_nx = pend_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_prev_q <= 1'b0;
      cnt_q      <= '0;
      irq_pin    <= 1'b1;
    end else begin
      any_prev_q <= any_g;
      cnt_q      <= cnt_nx;
      irq_pin    <= cfg.act_high ? active_nx : !active_nx;
    end
  end

  assert_gate_off_R3: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (irq_pin == !$past(cfg.act_high)));

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg.pulse_mode && glob_en) |=> (irq_pin == ($past(pend_any) == $past(cfg.act_high))));

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg.pulse_mode && $past(cfg.pulse_mode) && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_EP  = 15,
  parameter int DATA_W  = 32,
  parameter int PULSE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GEN_N-1:0]  gen_evt,
  input  logic [NUM_EP-1:0] ep_evt,
  input  logic [NUM_EP-1:0] ep_rd,
  input  logic              bus_status,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin
);
  localparam int EVT_W  = GEN_N + NUM_EP;
  localparam int STAT_W = EVT_W + 1;

  logic [EVT_W-1:0]  flags_q, en_evt;
  logic [STAT_W-1:0] stat_word, en_q;
  logic              glob_en_q, stat_clr;
  pin_cfg_t          cfg_q;

  assign stat_word = {flags_q[EVT_W-1:GEN_N], bus_status, flags_q[GEN_N-1:0]};
  assign en_evt    = {en_q[STAT_W-1:GEN_N+1], en_q[GEN_N-1:0]};

  irq_status_bank #(.NUM_EP(NUM_EP)) i_bank (
    .clk(clk), .rst(rst),
    .set_vec({ep_evt, gen_evt}),
    .stat_clr(stat_clr), .ep_clr(ep_rd),
    .flags_q(flags_q)
  );

  irq_reg_file #(.DATA_W(DATA_W), .STAT_W(STAT_W)) i_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .stat_word(stat_word), .reg_rdata(reg_rdata),
    .en_q(en_q), .glob_en_q(glob_en_q), .cfg_q(cfg_q), .stat_clr(stat_clr)
  );

  irq_pin_shaper #(.PULSE_W(PULSE_W)) i_shaper (
    .clk(clk), .rst(rst),
    .pend_any(|(flags_q & en_evt)),
    .glob_en(glob_en_q), .cfg(cfg_q),
    .irq_pin(irq_pin)
  );

  assert_bus_live_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_STAT_RD) |=> (reg_rdata[GEN_N] == $past(bus_status)));
endmodule

// File: tb/test_usb_irq_aggregator.sv
module test_usb_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 15;
  localparam int DATA_W = 32;
  localparam int PW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] gen_evt = '0;
  logic [NUM_EP-1:0] ep_evt = '0, ep_rd = '0;
  logic bus_status = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic irq_pin;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];
  logic rd_pend = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_aggregator #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .PULSE_W(PW)) i_usb_irq_aggregator (
    .clk(clk), .rst(rst), .gen_evt(gen_evt), .ep_evt(ep_evt), .ep_rd(ep_rd),
    .bus_status(bus_status), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin));

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: reads issued before a posedge are compared at the next negedge
  always @(posedge clk) rd_pend <= reg_rd;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [DATA_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DATA_W-1:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a; tick(); reg_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R4 reset state
    chk(irq_pin, 1, "R4 idle pin after reset");
    rd(8'h21, 0, "R4 enable reset");
    rd(8'h31, 0, "R4 mode reset");
    rd(8'h41, 0, "R4 cfg reset");
    rd(8'h10, 0, "R1 status reset");
    // R10 status write ignored, separate read/write addresses
    wr(8'h10, '1);
    rd(8'h10, 0, "R10 status write ignored");
    wr(8'h20, 32'h3F);
    rd(8'h21, 32'h3F, "R10 enable readback");
    rd(8'h20, 0, "R10 write address reads zero");
    // R2 masking and level assertion
    wr(8'h20, 32'h1FFFFB);
    wr(8'h30, 1);
    gen_evt[2] = 1'b1; tick(); gen_evt = '0;
    tick();
    chk(irq_pin, 1, "R2 masked event keeps pin idle");
    gen_evt[4] = 1'b1; tick(); gen_evt = '0;
    chk(irq_pin, 1, "R2 pin not yet active");
    tick();
    chk(irq_pin, 0, "R2 active-low level assert");
    // R6 clear on read
    rd(8'h10, 32'h14, "R6 pre-clear value");
    tick();
    chk(irq_pin, 1, "R6 pin released after clear");
    rd(8'h10, 0, "R6 bits cleared");
    // R3 global enable and R7 endpoint clearing
    ep_evt[3] = 1'b1; tick(); ep_evt = '0;
    tick();
    chk(irq_pin, 0, "R7 endpoint event asserts pin");
    wr(8'h30, 0);
    tick();
    chk(irq_pin, 1, "R3 global disable idles pin");
    rd(8'h10, 32'h200, "R7 endpoint bit after read");
    rd(8'h10, 32'h200, "R7 endpoint bit kept");
    ep_rd[3] = 1'b1; tick(); ep_rd = '0;
    rd(8'h10, 0, "R7 endpoint read strobe clears");
    // R9 same-cycle set and clear
    gen_evt[1] = 1'b1; tick(); gen_evt = '0;
    exp_q.push_back(32'h2); tag_q.push_back("R9 read during event");
    reg_rd = 1'b1; reg_addr = 8'h10; gen_evt[0] = 1'b1;
    ep_evt[0] = 1'b1; ep_rd[0] = 1'b1;
    tick();
    reg_rd = 1'b0; gen_evt = '0; ep_evt = '0; ep_rd = '0;
    rd(8'h10, 32'h41, "R9 event wins over clear");
    ep_rd[0] = 1'b1; tick(); ep_rd = '0;
    rd(8'h10, 0, "R9 cleanup");
    // R8 live bus bit
    wr(8'h20, 32'h1FFFFF);
    wr(8'h30, 1);
    bus_status = 1'b1;
    tick(); tick();
    rd(8'h10, 32'h20, "R8 live bus bit");
    chk(irq_pin, 1, "R8 bus bit does not drive pin");
    bus_status = 1'b0;
    rd(8'h10, 0, "R8 bus bit follows input");
    // R4 active-high level
    wr(8'h40, 1);
    tick();
    chk(irq_pin, 0, "R4 active-high idle");
    ep_evt[14] = 1'b1; tick(); ep_evt = '0;
    tick();
    chk(irq_pin, 1, "R4 active-high assert");
    ep_rd[14] = 1'b1; tick(); ep_rd = '0;
    tick();
    chk(irq_pin, 0, "R4 active-high release");
    // R5 pulse mode with a second rise inside the pulse
    wr(8'h40, 3);
    tick();
    gen_evt[4] = 1'b1; tick(); gen_evt = '0;
    hi = 0;
    for (int i = 1; i <= 20; i++) begin
      if (irq_pin) hi++;
      if (i == 3) begin
        exp_q.push_back(32'h10); tag_q.push_back("R5 read inside pulse");
        reg_rd = 1'b1; reg_addr = 8'h10;
      end
      if (i == 4) begin reg_rd = 1'b0; gen_evt[4] = 1'b1; end
      if (i == 5) gen_evt = '0;
      tick();
    end
    chk(hi, PW, "R5 pulse width without restart");
    chk(irq_pin, 0, "R5 pin idle after pulse");
    rd(8'h10, 32'h10, "R5 status after pulse");
    tick(); tick();
    gen_evt[3] = 1'b1; tick(); gen_evt = '0;
    hi = 0;
    for (int i = 0; i < 14; i++) begin
      if (irq_pin) hi++;
      tick();
    end
    chk(hi, PW, "R5 fresh rise gives new pulse");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule